// File: doc/BRIEF.md
# Protected clock select register

This block holds one 8-bit control byte that chooses clock sources for the surrounding clock tree: whether the system clock comes from the PLL, how the oscillator behaves in stop, whether the real-time interrupt runs from the oscillator, and which clock feeds the watchdog. Software reaches it through a simple register bus made up of an address, a write strobe, write data and read data. The byte answers at one fixed address and can be read at any time.

Every write is gated by a protection flag that comes from a separate protection register. With protection off, the operating mode decides which bits a write may change. In special mode every implemented bit is writable. In normal mode the two watchdog clock-select bits accept writes only until the watchdog configuration register has been written once.

When the oscillator stops being qualified, watchdog select bit 0 is forced low, and a later write may set it again once. Watchdog select bit 1 is not affected by oscillator loss. Each field is also driven out on its own port for the clock-tree logic. Read data always shows the current contents, so software can read back after a write to learn whether the write was accepted.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset the register reads 0x80: the PLL select bit (bit 7) is 1 and every other bit is 0. The watchdog lock and the re-arm permission are both clear.
- R2: The register answers only at address `REG_ADDR` (default 0x39). At that address `regRdata` returns the current contents at any time. At any other address `regRdata` is 0, and writes there change nothing.
- R3: While `protOn` is 1, no write changes any bit, in either operating mode.
- R4: In special mode (`specialMode`=1) with protection off, a write updates all implemented bits, which is mask 0xEF.
- R5: In normal mode with protection off, a write always updates bit 7 (PLL select), bit 6 (pseudo-stop), bit 3 (oscillator kept running in stop), bit 2 (clock enable) and bit 1 (RTI oscillator select).
- R6: In normal mode, bit 5 (watchdog select 1) and bit 0 (watchdog select 0) are writable until the first `wdCfgWrite` pulse and ignore writes after it. The lock takes effect from the clock edge after the pulse and stays set until reset.
- R7: On every clock edge where `oscGood` is 0, bit 0 is cleared. This takes priority over a write in the same cycle. Bit 5 is never changed by `oscGood`.
- R8: If an edge with `oscGood`=0 clears bit 0 while bit 0 is 1, then one later accepted normal-mode write may change bit 0 even while locked. The first such write that sets bit 0 to 1 uses up this permission.
- R9: Bit 4 is reserved. It always reads 0 and ignores writes.
- R10: The field outputs `selPll`, `pseudoStop`, `wdClkSel1`, `oscRunStop`, `clkEnable`, `rtiClkSel` and `wdClkSel0` always equal bits 7, 6, 5, 3, 2, 1 and 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register bus address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, 0 when the address does not match |
| protOn | input | 1 | Protection flag; 1 blocks every write |
| specialMode | input | 1 | 1 = special mode, 0 = normal mode |
| oscGood | input | 1 | Oscillator qualified; 0 clears watchdog select 0 |
| wdCfgWrite | input | 1 | Pulse marking a write to the watchdog configuration register |
| selPll | output | 1 | PLL select field |
| pseudoStop | output | 1 | Pseudo-stop field |
| wdClkSel1 | output | 1 | Watchdog clock select bit 1 |
| oscRunStop | output | 1 | Keep oscillator running in stop |
| clkEnable | output | 1 | Clock enable field |
| rtiClkSel | output | 1 | RTI oscillator select field |
| wdClkSel0 | output | 1 | Watchdog clock select bit 0 |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register at 0x39. Because of this, the bench can reach the matching address and a neighbouring address that must read 0 and ignore writes. Inside that frame it drives writes in both modes, before and after the watchdog lock, with and without protection, and with oscillator loss both alone and coinciding with a write. This covers the single re-arm of watchdog select 0, including a second attempt after the permission has been used. A reset in the middle of the run shows that the lock is cleared only by reset.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int SEL_W = 8;

  localparam int BIT_PLL  = 7;
  localparam int BIT_PSTP = 6;
  localparam int BIT_WD1  = 5;
  localparam int BIT_RSV  = 4;
  localparam int BIT_OSCS = 3;
  localparam int BIT_CEN  = 2;
  localparam int BIT_RTI  = 1;
  localparam int BIT_WD0  = 0;

  localparam logic [SEL_W-1:0] RST_VAL   = SEL_W'(1) << BIT_PLL;
  localparam logic [SEL_W-1:0] WD_MASK   = (SEL_W'(1) << BIT_WD1) | (SEL_W'(1) << BIT_WD0);
  localparam logic [SEL_W-1:0] IMPL_MASK = ~(SEL_W'(1) << BIT_RSV);
  localparam logic [SEL_W-1:0] FREE_MASK = IMPL_MASK & ~WD_MASK;

  typedef struct packed {
    logic             wrEn;
    logic [SEL_W-1:0] wrMask;
    logic             dropWd0;
  } selStrobe_t;
endpackage

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h39)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              wdataWd0,
  input  logic              protOn,
  input  logic              specialMode,
  input  logic              oscGood,
  input  logic              wdCfgWrite,
  input  logic              curWd0,
  output selStrobe_t        strb,
  output logic              lockFlag
);
  logic wdLocked;
  logic rearmQ;
  logic accept;
  logic useRearm;
  logic [SEL_W-1:0] normMask;

  assign accept   = regWr && (regAddr == REG_ADDR) && !protOn;
  assign useRearm = accept && !specialMode && wdLocked && rearmQ && wdataWd0;

  always_comb begin
    normMask = FREE_MASK;
    if (!wdLocked) normMask = normMask | WD_MASK;
    if (rearmQ)    normMask[BIT_WD0] = 1'b1;
  end

  always_comb begin
    strb.wrEn    = accept;
    strb.wrMask  = specialMode ? IMPL_MASK : normMask;
    strb.dropWd0 = !oscGood;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdLocked <= 1'b0;
      rearmQ   <= 1'b0;
    end else begin
      if (wdCfgWrite) wdLocked <= 1'b1;
      if (!oscGood && curWd0) rearmQ <= 1'b1;
      else if (useRearm)      rearmQ <= 1'b0;
    end
  end

  assign lockFlag = wdLocked;

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdLocked |=> wdLocked);
  p_rearm_after_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rearmQ) |-> $past(!oscGood));
endmodule

// File: rtl/clk_sel_dp.sv
module clk_sel_dp
  import clk_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  selStrobe_t       strb,
  input  logic [SEL_W-1:0] regWdata,
  output logic [SEL_W-1:0] selQ
);
  logic [SEL_W-1:0] nextVal;

  always_comb begin
    nextVal = selQ;
    if (strb.wrEn)    nextVal = (selQ & ~strb.wrMask) | (regWdata & strb.wrMask);
    if (strb.dropWd0) nextVal[BIT_WD0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= RST_VAL;
    else       selQ <= nextVal;
  end

  p_drop_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropWd0 |=> !selQ[BIT_WD0]);
  p_wd1_osc_blind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dropWd0 && !strb.wrEn) |=> $stable(selQ[BIT_WD1]));
endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h39)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              protOn,
  input  logic              specialMode,
  input  logic              oscGood,
  input  logic              wdCfgWrite,
  output logic              selPll,
  output logic              pseudoStop,
  output logic              wdClkSel1,
  output logic              oscRunStop,
  output logic              clkEnable,
  output logic              rtiClkSel,
  output logic              wdClkSel0
);
  selStrobe_t       strb;
  logic [SEL_W-1:0] selQ;
  logic             lockFlag;

  clk_sel_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .wdataWd0(regWdata[BIT_WD0]), .protOn(protOn), .specialMode(specialMode),
    .oscGood(oscGood), .wdCfgWrite(wdCfgWrite), .curWd0(selQ[BIT_WD0]),
    .strb(strb), .lockFlag(lockFlag)
  );

  clk_sel_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .selQ(selQ)
  );

  assign regRdata   = (regAddr == REG_ADDR) ? selQ : '0;
  assign selPll     = selQ[BIT_PLL];
  assign pseudoStop = selQ[BIT_PSTP];
  assign wdClkSel1  = selQ[BIT_WD1];
  assign oscRunStop = selQ[BIT_OSCS];
  assign clkEnable  = selQ[BIT_CEN];
  assign rtiClkSel  = selQ[BIT_RTI];
  assign wdClkSel0  = selQ[BIT_WD0];

  p_prot_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (protOn && oscGood) |=> $stable(selQ));
  p_wd1_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && !specialMode) |=> $stable(selQ[BIT_WD1]));
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> (selQ[BIT_RSV] == 1'b0));
  p_other_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr != REG_ADDR && oscGood) |=> $stable(selQ));
endmodule

// File: tb/sim_clk_src_ctl.sv
`timescale 1ns/1ps
module sim_clk_src_ctl;
  logic clk = 0;
  logic rstN = 0;
  logic [7:0] regAddr = 8'h39;
  logic regWr = 0;
  logic [7:0] regWdata = 0;
  logic [7:0] regRdata;
  logic protOn = 0, specialMode = 0, oscGood = 1, wdCfgWrite = 0;
  logic selPll, pseudoStop, wdClkSel1, oscRunStop, clkEnable, rtiClkSel, wdClkSel0;

  int checks = 0, failures = 0;
  int mdl = 8'h80;
  bit locked = 0, rearm = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_src_ctl u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    int fields;
    fields = {selPll, pseudoStop, wdClkSel1, 1'b0, oscRunStop, clkEnable, rtiClkSel, wdClkSel0};
    chk(req, regRdata, (regAddr == 8'h39) ? mdl : 0);
    chk({req, " R10"}, fields, mdl);
  endtask

  task automatic step(string req, logic [7:0] a, logic w, logic [7:0] d,
                      logic p, logic s, logic o, logic wd);
    int nv, mask;
    bit acc;
    @(negedge clk);
    regAddr = a; regWr = w; regWdata = d; protOn = p;
    specialMode = s; oscGood = o; wdCfgWrite = wd;
    @(posedge clk);
    nv = mdl;
    acc = w && a == 8'h39 && !p;
    if (s) mask = 8'hEF;
    else mask = 8'hCE | (locked ? 0 : 8'h21) | (rearm ? 1 : 0);
    if (acc) nv = (mdl & ~mask) | (d & mask);
    if (!o) nv = nv & 8'hFE;
    if (!o && mdl[0]) rearm = 1;
    else if (acc && !s && locked && rearm && d[0]) rearm = 0;
    if (wd) locked = 1;
    mdl = nv;
    #1;
    compare(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #9 compare("R1");
    @(negedge clk) rstN = 1;
    #1 compare("R1");
    step("R5 R6 R9", 8'h39, 1, 8'hFF, 0, 0, 1, 0);
    chk("R9", regRdata, 8'hEF);
    step("R3", 8'h39, 1, 8'h00, 1, 0, 1, 0);
    step("R3", 8'h39, 1, 8'h00, 1, 1, 1, 0);
    step("R2", 8'h3A, 1, 8'h00, 0, 0, 1, 0);
    chk("R2", regRdata, 0);
    step("R2", 8'h39, 0, 8'h00, 0, 0, 1, 0);
    step("R5", 8'h39, 1, 8'h00, 0, 0, 1, 0);
    step("R6", 8'h39, 1, 8'h21, 0, 0, 1, 1);
    step("R6", 8'h39, 1, 8'h00, 0, 0, 1, 0);
    chk("R6", regRdata, 8'h21);
    step("R5", 8'h39, 1, 8'hCE, 0, 0, 1, 0);
    chk("R5", regRdata, 8'hEF);
    step("R4", 8'h39, 1, 8'h00, 0, 1, 1, 0);
    chk("R4", regRdata, 8'h00);
    step("R4", 8'h39, 1, 8'h21, 0, 1, 1, 0);
    step("R7", 8'h39, 0, 8'h00, 0, 0, 0, 0);
    chk("R7", regRdata, 8'h20);
    step("R8", 8'h39, 1, 8'h01, 0, 0, 1, 0);
    chk("R8", regRdata, 8'h21);
    step("R8", 8'h39, 1, 8'h00, 0, 0, 1, 0);
    chk("R8", regRdata, 8'h21);
    step("R7", 8'h39, 1, 8'hFF, 0, 1, 0, 0);
    chk("R7", regRdata, 8'hEE);
    step("R7", 8'h39, 1, 8'h01, 1, 0, 0, 0);
    step("R8", 8'h39, 1, 8'h01, 0, 0, 1, 0);
    @(negedge clk) rstN = 0;
    mdl = 8'h80; locked = 0; rearm = 0;
    #1 compare("R1");
    @(negedge clk) rstN = 1;
    step("R6", 8'h39, 1, 8'h21, 0, 0, 1, 0);
    chk("R6", regRdata, 8'h21);
    for (int i = 0; i < 40; i++)
      step("R2 R5", (i % 3 == 0) ? 8'h38 : 8'h39, i[0], 8'((i * 37) ^ 8'h5A),
           i % 5 == 0, i % 7 == 0, i % 6 != 0, i == 20);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule